// File: doc/BRIEF.md
# UART Interrupt Identification Register

This block gathers the interrupt requests of one serial channel and reports the most urgent one through an 8-bit identification byte. Each request arrives as a one-cycle set pulse and is held as pending. Before ranking, each pending bit is gated by its own enable, and the two extended sources are also gated by an extended-features switch. The fixed ranking runs from receive line errors at the top down to flow-control pin changes at the bottom. The interrupt line is high while any gated source is pending.

A host read is a one-cycle strobe. On that clock edge the current identification byte is captured into the read register. In the same edge, only the source named by that byte is acknowledged. Any lower-ranked source that is still pending is named by the next read. The Xoff/special-character source works differently: a read does not clear it, and only an Xon-received pulse does.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset `isr_o` is 0x01 and `irq_o` is 0.
- R2: A single pending source reads back as bits [5:0] = 0x06 (line status, src bit 0), 0x04 (receive data ready, bit 1), 0x0C (receive timeout, bit 2), 0x02 (transmit empty, bit 3), 0x00 (modem status, bit 4), 0x10 (Xoff/special, bit 5), 0x20 (flow pin change, bit 6).
- R3: Rank follows source bit index, with bit 0 highest. A lower-ranked source is not reported while a higher-ranked one is pending.
- R4: A read acknowledges only the source it reports. The next read reports the next pending lower-ranked source.
- R5: Data ready and receive timeout share one rank. When both are pending, data ready (0x04) is reported first.
- R6: Bit 0 of the byte is active low. `irq_o` is 1 exactly when a gated source is pending. With nothing pending, a read returns 0x01, or 0xC1 when FIFOs are enabled.
- R7: Bits [7:6] of a read both equal `fifo_en_i` as it was in the read cycle.
- R8: With `ext_en_i` = 0, sources 5 and 6 are not reported and do not raise `irq_o`. They stay pending, and they report once `ext_en_i` = 1.
- R9: A source whose `src_en_i` bit is 0 is not reported and does not raise `irq_o`. It stays pending and reports once enabled.
- R10: The Xoff/special source is not cleared by reads. It clears only on an `xon_i` pulse.
- R11: `isr_o` changes only on the clock edge that samples `rd_i` = 1. It holds its value in every other cycle.
- R12: A set pulse that arrives in the same cycle as the acknowledge of that source leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_set_i | input | 7 | One-cycle set pulse per source, bit index = rank |
| src_en_i | input | 7 | Per-source enable |
| ext_en_i | input | 1 | Enables sources 5 and 6 |
| fifo_en_i | input | 1 | FIFO mode flag, shown in bits [7:6] |
| rd_i | input | 1 | Host read strobe, one cycle |
| xon_i | input | 1 | Xon-received pulse, clears source 5 |
| isr_o | output | 8 | Identification byte captured at the last read |
| irq_o | output | 1 | Interrupt request, high while a gated source is pending |

## Verification
A set pulse becomes pending at the next edge, so `irq_o` is sampled on the falling edge after the pulse. A read captures `isr_o` at the edge where `rd_i` is high. The bench drops the strobe on the next falling edge and samples there. The acknowledge takes effect at that same edge, so the read that follows immediately already sees the next source. An exhaustive sweep of all 128 set patterns replays the ranking one read at a time, and each read is compared with a value computed arithmetically from the codes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int N_SRC = 7;
  localparam int ISR_W = 8;
  localparam int CODE_W = 6;

  typedef enum int {
    SRC_LINE  = 0,
    SRC_RXRDY = 1,
    SRC_RXTO  = 2,
    SRC_THRE  = 3,
    SRC_MODEM = 4,
    SRC_XOFF  = 5,
    SRC_FLOW  = 6
  } src_e;

  // sources gated by the extended-features switch
  localparam logic [N_SRC-1:0] EXT_MASK    = N_SRC'((1 << SRC_XOFF) | (1 << SRC_FLOW));
  // sources cleared by a release event instead of a read
  localparam logic [N_SRC-1:0] STICKY_MASK = N_SRC'(1 << SRC_XOFF);

  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      SRC_LINE:  src_code = 6'h06;
      SRC_RXRDY: src_code = 6'h04;
      SRC_RXTO:  src_code = 6'h0C;
      SRC_THRE:  src_code = 6'h02;
      SRC_MODEM: src_code = 6'h00;
      SRC_XOFF:  src_code = 6'h10;
      SRC_FLOW:  src_code = 6'h20;
      default:   src_code = 6'h00;
    endcase
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 7,
  parameter logic [N-1:0] STICKY = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] ack_i,
  input  logic         rel_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic clr;
    if (STICKY[i]) begin : g_sticky
      assign clr = rel_i;
    end else begin : g_plain
      assign clr = ack_i[i];
    end
    // set wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[i] <= 1'b0;
      else         pend_o[i] <= set_i[i] | (pend_o[i] & ~clr);
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 7
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  always_comb begin
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) grant_o = N'(1) << i;
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_set_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic             ext_en_i,
  input  logic             fifo_en_i,
  input  logic             rd_i,
  input  logic             xon_i,
  output logic [ISR_W-1:0] isr_o,
  output logic             irq_o
);
  logic [N_SRC-1:0]  pend_q, gated, grant, ack;
  logic              any;
  logic [CODE_W-1:0] code;
  logic [ISR_W-1:0]  live;

  irq_pend_bank #(.N(N_SRC), .STICKY(STICKY_MASK)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (src_set_i),
    .ack_i  (ack),
    .rel_i  (xon_i),
    .pend_o (pend_q)
  );

  assign gated = pend_q & src_en_i & (ext_en_i ? '1 : ~EXT_MASK);

  irq_prio_pick #(.N(N_SRC)) u_pick (
    .req_i   (gated),
    .grant_o (grant),
    .any_o   (any)
  );

  always_comb begin
    code = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (grant[i]) code = code | src_code(i);
    end
  end

  assign live  = {{2{fifo_en_i}}, code[CODE_W-1:1], ~any};
  assign ack   = rd_i ? grant : '0;
  assign irq_o = any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   isr_o <= 8'h01;
    else if (rd_i) isr_o <= live;
  end
endmodule

// File: rtl/irq_ident_chk.sv
module irq_ident_chk
  import uart_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_i,
  input logic             xon_i,
  input logic             fifo_en_i,
  input logic             irq_o,
  input logic [ISR_W-1:0] isr_o,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] grant
);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(isr_o));
  p_idle_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !irq_o) |=> isr_o[0]);
  p_busy_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && irq_o) |=> !isr_o[0]);
  p_fifo_bits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (isr_o[7:6] == {2{$past(fifo_en_i)}}));
  p_xoff_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend[SRC_XOFF] && !xon_i) |=> pend[SRC_XOFF]);
  p_one_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (irq_o == (grant != '0)));
endmodule

bind uart_irq_ident irq_ident_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_i      (rd_i),
  .xon_i     (xon_i),
  .fifo_en_i (fifo_en_i),
  .irq_o     (irq_o),
  .isr_o     (isr_o),
  .pend      (pend_q),
  .grant     (grant)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] set = '0;
  logic [6:0] en = '1;
  logic       ext = 1'b1;
  logic       fifo = 1'b0;
  logic       rd = 1'b0;
  logic       xon = 1'b0;
  logic [7:0] isr;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  uart_irq_ident uut (
    .clk_i(clk), .rst_ni(rst_n), .src_set_i(set), .src_en_i(en),
    .ext_en_i(ext), .fifo_en_i(fifo), .rd_i(rd), .xon_i(xon),
    .isr_o(isr), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] code_of(input int idx);
    case (idx)
      0: code_of = 8'h06;
      1: code_of = 8'h04;
      2: code_of = 8'h0C;
      3: code_of = 8'h02;
      4: code_of = 8'h00;
      5: code_of = 8'h10;
      default: code_of = 8'h20;
    endcase
  endfunction

  function automatic int top_of(input logic [6:0] m);
    int r = -1;
    for (int i = 6; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction

  function automatic logic [7:0] expect_of(input logic [6:0] m, input logic f);
    if (m == 0) return {f, f, 6'h01};
    return {f, f, 6'h00} | code_of(top_of(m));
  endfunction

  task automatic pulse(input logic [6:0] v);
    @(negedge clk); set = v;
    @(negedge clk); set = '0;
  endtask

  task automatic pulse_xon();
    @(negedge clk); xon = 1'b1;
    @(negedge clk); xon = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = isr;
  endtask

  logic [7:0] v;
  logic [6:0] m;

  initial begin
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset isr", isr, 8'h01);
    check("R1 reset irq", {7'd0, irq}, 8'h00);

    // R2 each source alone, both FIFO modes
    for (int s = 0; s < 7; s++) begin
      fifo = s[0];
      pulse(7'(1 << s));
      do_read(v);
      check("R2 single code", v, {fifo, fifo, 6'h00} | code_of(s));
      if (s == 5) pulse_xon();
      do_read(v);
      check("R6 idle after single", v, {fifo, fifo, 6'h01});
    end

    // R11 isr holds while sources change without a read
    pulse(7'b0000001);
    repeat (3) begin
      @(negedge clk);
      check("R11 hold", isr, {fifo, fifo, 6'h01});
    end
    do_read(v);
    check("R11 update on read", v, {fifo, fifo, 6'h06});

    // R5 shared rank
    fifo = 1'b0;
    pulse(7'b0000110);
    do_read(v); check("R5 data ready first", v, 8'h04);
    do_read(v); check("R5 timeout next", v, 8'h0C);
    do_read(v); check("R6 idle", v, 8'h01);

    // R12 set wins over same-cycle ack
    pulse(7'b0001000);
    @(negedge clk); rd = 1'b1; set = 7'b0001000;
    @(negedge clk); rd = 1'b0; set = '0;
    check("R12 read code", isr, 8'h02);
    do_read(v); check("R12 still pending", v, 8'h02);
    do_read(v); check("R12 then idle", v, 8'h01);

    // R9 per-source enable
    en = 7'b1111110;
    pulse(7'b0001001);
    do_read(v); check("R9 masked source skipped", v, 8'h02);
    @(negedge clk); check("R9 irq low while masked", {7'd0, irq}, 8'h00);
    en = '1;
    @(negedge clk); check("R9 irq after enable", {7'd0, irq}, 8'h01);
    do_read(v); check("R9 reports once enabled", v, 8'h06);
    do_read(v); check("R9 idle", v, 8'h01);

    // R8 extended gating
    ext = 1'b0;
    pulse(7'b1100000);
    check("R8 irq low when gated", {7'd0, irq}, 8'h00);
    do_read(v); check("R8 gated read idle", v, 8'h01);
    ext = 1'b1;
    do_read(v); check("R8 xoff after enable", v, 8'h10);
    do_read(v); check("R10 xoff sticky", v, 8'h10);
    pulse_xon();
    do_read(v); check("R10 cleared by xon, flow next", v, 8'h20);
    do_read(v); check("R8 idle", v, 8'h01);

    // R3 R4 R6 R7 R10 exhaustive sweep over set patterns
    for (int p = 0; p < 128; p++) begin
      logic [6:0] pv;
      pv = 7'(p);
      fifo = pv[1] ^ pv[4];
      pulse(pv);
      m = pv;
      check("R6 irq level", {7'd0, irq}, {7'd0, (m != 0)});
      while (m != 0) begin
        int t;
        t = top_of(m);
        do_read(v);
        check("R3 R4 ranked read", v, expect_of(m, fifo));
        if (t == 5) begin
          do_read(v);
          check("R10 sticky in sweep", v, expect_of(m, fifo));
          pulse_xon();
        end
        m[t] = 1'b0;
      end
      do_read(v);
      check("R6 R7 idle in sweep", v, {fifo, fifo, 6'h01});
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule